// File: doc/BRIEF.md
# Two-Half Packet Buffer with Late Keep/Drop

This block buffers byte-wide frames between a producer that decides late whether a frame is worth keeping and a consumer that drains kept frames in order. Storage is split into two equal halves. The writer fills one half while the reader empties the other. A frame is assigned a whole half.

While a frame is being written, an external decision stage settles its fate, and the delay before that decision is also set outside this block. A drop rewinds the write address of the current half to zero, so the same half can be refilled at once. A keep seals the half, records its byte count, hands the half to the reader and moves the writer to the other half. There is no empty flag, because the read and write sides may be working in different halves. The reader reports data-available while it owns a sealed half. It frees that half when the last recorded byte has been read.

Correct flow assumes that two interpacket gaps plus the write time of a frame are longer than the time taken to drain a half. When that assumption is broken, the writer finds its next half still sealed or being read. The block then refuses the frame and pulses an overflow flag.

The writer machine has two states. In `W_FILL` it stores bytes into the current half. In `W_SKIP` it throws away the rest of a refused frame. `W_FILL -> W_SKIP` happens on a refused byte when no keep or drop arrives in the same cycle. `W_SKIP -> W_FILL` happens on keep or drop. A keep or drop in `W_FILL` stays in `W_FILL` and rewinds the address.

The reader machine also has two states. `RD_IDLE -> RD_BUSY` happens when the half it expects next is sealed. `RD_BUSY -> RD_IDLE` happens when the last byte of that half is read, and the reader then moves to the other half.

Top module: `dbf_drop_buffer`

## Requirements
- R1: After reset, `rd_avail` and `overflow` are 0, `rd_data` is 0, and both the writer and the reader point at half 0.
- R2: A read accepted while `rd_avail` is 1 (`rd_en`=1 at a rising edge) drives the next byte of the kept frame on `rd_data` after that edge. Bytes come out in the order they were written.
- R3: A drop rewinds the current half, and the next frame is written into that same half.
- R4: A keep seals a frame into the current half. When the reader is idle on that half, `rd_avail` is still 0 after the keep edge and is 1 after the following edge.
- R5: Kept frames use the two halves alternately and are read back in the order they were kept.
- R6: A frame whose first byte arrives while its target half is still sealed or being read is discarded whole. `overflow` is 1 for the cycle after the refused byte, and the frames already stored are unaffected.
- R7: A frame of exactly DEPTH bytes is stored. On a frame longer than DEPTH, the byte after the DEPTH-th raises one `overflow` pulse and the frame is discarded.
- R8: A keep for a frame with no bytes behaves as a drop: no half is sealed and `rd_avail` stays 0.
- R9: `rd_en` while `rd_avail` is 0 has no effect, and `rd_data` keeps its value.
- R10: When keep and drop are asserted together, drop wins and the frame is discarded.
- R11: A byte written in the same cycle as keep or drop belongs to the frame being closed.
- R12: The writer can fill one half while the reader drains the other, and the two frames do not disturb each other.
- R13: `rd_avail` is 0 after the edge that accepts the last byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | DATA_W | Byte to store |
| keep | input | 1 | Close the current frame and hand it to the reader |
| drop | input | 1 | Close the current frame and discard it |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Byte read, valid after the accepting edge |
| rd_avail | output | 1 | Reader owns a sealed half with bytes still to be read |
| overflow | output | 1 | One-cycle pulse when a frame is refused |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A drop while the other half is sealed: a design that switched halves on drop would refuse the next frame with an overflow.
- A frame of DEPTH bytes and one of DEPTH+3 bytes: an off-by-one in the full test would truncate the first frame or keep the second.
- Keep with no bytes, keep together with drop, and `rd_en` while idle: a design that got these wrong would raise `rd_avail` for an empty frame, keep a frame that should be discarded, or change `rd_data`.
- A read running alongside a write: a design that let the writer into the busy half, or that counted the closing byte wrongly, would return corrupted or shortened frames.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    typedef enum logic {
        W_FILL = 1'b0,
        W_SKIP = 1'b1
    } wr_state_t;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_BUSY = 1'b1
    } rd_state_t;
endpackage

// File: rtl/dbf_store.sv
module dbf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2048,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW:0]       waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW:0]       raddr,
    output logic [DATA_W-1:0] rdata
);
    // Both halves share one array; the top address bit selects the half.
    logic [DATA_W-1:0] mem [0:2*DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/dbf_half_status.sv
module dbf_half_status #(
    parameter int LW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set,
    input  logic                set_half,
    input  logic [LW-1:0]       set_len,
    input  logic                clr,
    input  logic                clr_half,
    output logic [1:0]          ready,
    output logic [1:0][LW-1:0]  len
);
    // One sealed flag and one byte count per half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ready[h] <= 1'b0;
                len[h]   <= '0;
            end else if (set && (set_half == 1'(h))) begin
                ready[h] <= 1'b1;
                len[h]   <= set_len;
            end else if (clr && (clr_half == 1'(h))) begin
                ready[h] <= 1'b0;
            end
        end
    end

    // R12
    set_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set && clr && (set_half == clr_half)));

    // R5
    seal_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |-> !ready[set_half]);
endmodule

// File: rtl/dbf_write_ctrl.sv
module dbf_write_ctrl
    import dbf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          keep,
    input  logic          drop,
    input  logic [1:0]    half_busy,
    output logic          mem_we,
    output logic [AW:0]   mem_waddr,
    output logic          seal,
    output logic          seal_half,
    output logic [LW-1:0] seal_len,
    output logic          overflow
);
    wr_state_t     st, st_n;
    logic [LW-1:0] waddr, waddr_n;
    logic          wsel, wsel_n;
    logic          ovf_n;
    logic [LW-1:0] cnt;
    logic          blocked, full;

    assign blocked   = half_busy[wsel] && (waddr == '0);
    assign full      = (waddr == LW'(DEPTH));
    assign mem_waddr = {wsel, waddr[AW-1:0]};
    assign seal_half = wsel;
    assign seal_len  = cnt;

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= W_FILL;
            waddr    <= '0;
            wsel     <= 1'b0;
            overflow <= 1'b0;
        end else begin
            st       <= st_n;
            waddr    <= waddr_n;
            wsel     <= wsel_n;
            overflow <= ovf_n;
        end
    end

    // Next-state and output process.
    always_comb begin
        st_n    = st;
        waddr_n = waddr;
        wsel_n  = wsel;
        mem_we  = 1'b0;
        seal    = 1'b0;
        ovf_n   = 1'b0;
        cnt     = waddr;
        unique case (st)
            W_FILL: begin
                if (wr_en && (blocked || full)) begin
                    ovf_n   = 1'b1;
                    waddr_n = '0;
                    st_n    = (keep || drop) ? W_FILL : W_SKIP;
                end else begin
                    mem_we = wr_en;
                    cnt    = waddr + {{(LW-1){1'b0}}, wr_en};
                    if (drop) begin
                        waddr_n = '0;
                    end else if (keep) begin
                        waddr_n = '0;
                        if (cnt != '0) begin
                            seal   = 1'b1;
                            wsel_n = ~wsel;
                        end
                    end else begin
                        waddr_n = cnt;
                    end
                end
            end
            W_SKIP: begin
                if (keep || drop) begin
                    st_n = W_FILL;
                end
            end
            default: st_n = W_FILL;
        endcase
    end

    // R6
    no_fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (waddr == '0)) |-> !half_busy[wsel]);

    // R7
    waddr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waddr <= LW'(DEPTH));
endmodule

// File: rtl/dbf_read_ctrl.sv
module dbf_read_ctrl
    import dbf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [1:0]         half_ready,
    input  logic [1:0][LW-1:0] half_len,
    output logic               mem_re,
    output logic [AW:0]        mem_raddr,
    output logic               release_half,
    output logic               release_sel,
    output logic               rd_avail
);
    rd_state_t     st, st_n;
    logic [LW-1:0] raddr, raddr_n;
    logic          rsel, rsel_n;
    logic          at_last;

    assign at_last     = (raddr == (half_len[rsel] - LW'(1)));
    assign mem_raddr   = {rsel, raddr[AW-1:0]};
    assign release_sel = rsel;

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RD_IDLE;
            raddr <= '0;
            rsel  <= 1'b0;
        end else begin
            st    <= st_n;
            raddr <= raddr_n;
            rsel  <= rsel_n;
        end
    end

    // Next-state and output process.
    always_comb begin
        st_n         = st;
        raddr_n      = raddr;
        rsel_n       = rsel;
        mem_re       = 1'b0;
        release_half = 1'b0;
        rd_avail     = 1'b0;
        unique case (st)
            RD_IDLE: begin
                if (half_ready[rsel]) begin
                    st_n    = RD_BUSY;
                    raddr_n = '0;
                end
            end
            RD_BUSY: begin
                rd_avail = 1'b1;
                if (rd_en) begin
                    mem_re  = 1'b1;
                    raddr_n = raddr + LW'(1);
                    if (at_last) begin
                        release_half = 1'b1;
                        rsel_n       = ~rsel;
                        st_n         = RD_IDLE;
                    end
                end
            end
            default: st_n = RD_IDLE;
        endcase
    end

    // R4
    avail_sealed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_avail |-> half_ready[rsel]);

    // R13
    release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_half |=> !rd_avail);
endmodule

// File: rtl/dbf_drop_buffer.sv
module dbf_drop_buffer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              keep,
    input  logic              drop,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_avail,
    output logic              overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic               mem_we, mem_re;
    logic [AW:0]        mem_waddr, mem_raddr;
    logic               seal, seal_half;
    logic [LW-1:0]      seal_len;
    logic               rel, rel_sel;
    logic [1:0]         ready;
    logic [1:0][LW-1:0] len;

    dbf_write_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .keep      (keep),
        .drop      (drop),
        .half_busy (ready),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .seal      (seal),
        .seal_half (seal_half),
        .seal_len  (seal_len),
        .overflow  (overflow)
    );

    dbf_read_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .half_ready   (ready),
        .half_len     (len),
        .mem_re       (mem_re),
        .mem_raddr    (mem_raddr),
        .release_half (rel),
        .release_sel  (rel_sel),
        .rd_avail     (rd_avail)
    );

    dbf_half_status #(.LW(LW)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (seal),
        .set_half (seal_half),
        .set_len  (seal_len),
        .clr      (rel),
        .clr_half (rel_sel),
        .ready    (ready),
        .len      (len)
    );

    dbf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (rd_data)
    );

    // R9
    idle_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_avail) |=> $stable(rd_data));
endmodule

// File: tb/sim_dbf_drop_buffer.sv
module sim_dbf_drop_buffer;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, keep = 1'b0, drop = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_avail, overflow;

    int checks = 0, errors = 0, ovf_cnt = 0;
    bit m_ready [2];
    int m_len   [2];
    logic [7:0] m_mem [2][DEPTH];
    bit m_wsel = 1'b0, m_rsel = 1'b0;

    always #4 clk = ~clk;

    dbf_drop_buffer #(.DATA_W(8), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .keep(keep), .drop(drop), .rd_en(rd_en), .rd_data(rd_data),
        .rd_avail(rd_avail), .overflow(overflow)
    );

    always @(negedge clk) if (rst_n && overflow) ovf_cnt++;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ovf(int len, bit busy);
        return ((len > 0) && (busy || (len > DEPTH))) ? 1 : 0;
    endfunction

    // dec: 0 keep, 1 drop, 2 keep and drop together
    task automatic write_frame(int len, int dec);
        int  ovf0 = ovf_cnt;
        bit  h = m_wsel;
        bit  busy = m_ready[h];
        bit  idle_both = !m_ready[0] && !m_ready[1];
        int  eo = exp_ovf(len, busy);
        bit  stored = (eo == 0) && (dec == 0) && (len > 0);
        logic [7:0] buf_q [DEPTH];
        for (int i = 0; i < len; i++) begin
            logic [7:0] b = 8'($urandom);
            @(negedge clk);
            wr_en = 1'b1; wr_data = b;
            keep = (i == len-1) && (dec != 1);
            drop = (i == len-1) && (dec != 0);
            if (i < DEPTH) buf_q[i] = b;
        end
        if (len == 0) begin
            @(negedge clk);
            keep = (dec != 1); drop = (dec != 0);
        end
        @(negedge clk);
        wr_en = 1'b0; keep = 1'b0; drop = 1'b0;
        if (stored && idle_both)
            chk(rd_avail == 1'b0, "R4 avail low after keep edge", int'(rd_avail), 0);
        @(negedge clk);
        if (stored && idle_both)
            chk(rd_avail == 1'b1, "R4 avail high one edge later", int'(rd_avail), 1);
        @(negedge clk);
        chk((ovf_cnt - ovf0) == eo, (len > DEPTH) ? "R7 overflow count" : "R6 overflow count",
            ovf_cnt - ovf0, eo);
        if (stored) begin
            m_ready[h] = 1'b1;
            m_len[h]   = len;
            for (int i = 0; i < len; i++) m_mem[h][i] = buf_q[i];
            m_wsel = ~m_wsel;
        end
    endtask

    task automatic read_one(string req);
        bit h = m_rsel;
        int w = 0;
        if (!m_ready[h]) return;
        while (!rd_avail && w < 4) begin @(negedge clk); w++; end
        chk(rd_avail == 1'b1, "R4 avail for sealed half", int'(rd_avail), 1);
        for (int i = 0; i < m_len[h]; i++) begin
            rd_en = 1'b1;
            @(negedge clk);
            chk(rd_data == m_mem[h][i], req, int'(rd_data), int'(m_mem[h][i]));
        end
        rd_en = 1'b0;
        chk(rd_avail == 1'b0, "R13 avail low after last byte", int'(rd_avail), 0);
        m_ready[h] = 1'b0;
        m_rsel = ~m_rsel;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd41));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_avail == 1'b0, "R1 rd_avail", int'(rd_avail), 0);
        chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
        chk(rd_data == 8'h00, "R1 rd_data", int'(rd_data), 0);

        // R9 read request while idle
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
        chk(rd_data == 8'h00, "R9 rd_data unchanged", int'(rd_data), 0);

        // R2 R11 single frame
        write_frame(5, 0);
        read_one("R2 R11 frame bytes");

        // R8 empty keep
        write_frame(0, 0);
        repeat (3) @(negedge clk);
        chk(rd_avail == 1'b0, "R8 empty keep no avail", int'(rd_avail), 0);

        // R3 drop reuses half; R6 busy half refused
        write_frame(4, 0);
        write_frame(8, 1);
        write_frame(6, 0);
        write_frame(3, 0);
        read_one("R3 R5 first kept");
        read_one("R3 R5 second kept");

        // R10 keep and drop together
        write_frame(6, 2);
        repeat (3) @(negedge clk);
        chk(rd_avail == 1'b0, "R10 drop wins", int'(rd_avail), 0);

        // R7 depth boundaries
        write_frame(DEPTH, 0);
        read_one("R7 full frame bytes");
        write_frame(DEPTH + 3, 0);
        repeat (3) @(negedge clk);
        chk(rd_avail == 1'b0, "R7 oversize discarded", int'(rd_avail), 0);

        // R12 concurrent read and write in different halves
        write_frame(9, 0);
        fork
            read_one("R12 frame being drained");
            write_frame(7, 0);
        join
        read_one("R12 frame written alongside");

        // Random mix
        for (int it = 0; it < 200; it++) begin
            int op = int'($urandom % 3);
            if (op == 0 && (m_ready[0] || m_ready[1])) begin
                read_one("R2 R5 random read");
            end else begin
                int l = int'($urandom % 24);
                int d = int'($urandom % 4);
                if ($urandom % 16 == 0) l = DEPTH + 1;
                write_frame(l, (d == 3) ? 0 : d);
            end
        end
        read_one("R5 drain");
        read_one("R5 drain");
        finish_run();
    end
endmodule